// File: doc/BRIEF.md
# Floating-Point Status and Control Word

This block keeps the status and control word of a small floating-point unit. A processor reads and writes the word through a simple port. The arithmetic datapath connects through a status interface. On that interface it reports exception events and the outcome of compare operations, and from it the datapath receives the active rounding mode.

Five exception kinds are tracked: invalid operation, divide by zero, overflow, underflow and inexact. The datapath raises them as events, and the block collects them in a sticky accumulator that only a write can clear. A read returns the stored control bits limited to the writable fields, with the accumulator ORed in live.

A write does three things:
- It replaces the stored word with its writable bits.
- It reloads the accumulator from the trap-enable field.
- It re-evaluates the rounding field. This happens only when the field's bits differ from the stored ones.

Codes that name no supported rounding direction raise an error indication and leave the active mode where it was. A parameter selects how that indication behaves: as a single-cycle pulse, or held until a supported code is written.

Top module: `fpu_stat_ctl`

## Requirements
- R1: After reset the read word is zero, the rounding mode output is 0 (nearest even) and the error output is low.
- R2: A write stores only the writable bits: rounding code bits 2:0, flag field bits 7:3, trap-enable field bits 12:8 and compare bit 29. All other read bits are zero.
- R3: A read returns the stored writable bits ORed with the accumulated flags in bits 7:3. The bit order is invalid (bit 3), divide by zero (bit 4), overflow (bit 5), underflow (bit 6) and inexact (bit 7).
- R4: In every cycle with the event valid input high, the event flag vector is ORed into the accumulator, visible one cycle later. Flags are never cleared by events, and the vector is ignored while valid is low.
- R5: Every write replaces the accumulator with the written trap-enable field, bits 12:8, in the same bit order as R3.
- R6: A write in the same cycle as an exception event or a compare result takes priority, and the event or result is discarded.
- R7: A write that changes the rounding code to 0, 1, 2 or 3 sets the mode output, in the next cycle, to that code. The codes mean nearest even, toward zero, toward plus infinity and toward minus infinity, in that order.
- R8: The mode output and the error output react only to writes that change the rounding code bits. A write of the code already stored changes neither.
- R9: A write that changes the rounding code to a value of 4 or above keeps the previous mode and raises the error output in the next cycle.
- R10: With ERR_HOLD=0 the error is high for exactly one cycle. With ERR_HOLD=1 it stays high until a write carries a code of 0 to 3.
- R11: A compare result with its valid input high, and no write in that cycle, is stored in bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Processor write strobe |
| wr_data_i | input | 32 | Processor write word |
| rd_data_o | output | 32 | Read word (stored bits merged with accumulated flags) |
| ev_valid_i | input | 1 | Exception event valid from datapath |
| ev_flags_i | input | 5 | Exception event flags, same order as R3 |
| cmp_valid_i | input | 1 | Compare result valid from datapath |
| cmp_result_i | input | 1 | Compare result bit |
| rnd_mode_o | output | 2 | Active rounding mode to datapath |
| rnd_err_o | output | 1 | Unsupported rounding code indication |

## Verification
The bench builds two copies from the same stimulus. One uses the default ERR_HOLD=0 and the other uses ERR_HOLD=1, so both error variants are checked against the same sequence of rounding codes. That sequence includes a repeated unsupported code, an unsupported-to-unsupported change and a recovery write. These make it possible to tell the single-cycle pulse from the held indication. They also show that an unchanged field write leaves both variants alone. The field positions are the defaults, which places every writable field, the compare bit and the unwritable gaps inside the one 32-bit word that the checks compare.

// File: rtl/fpu_stat_pkg.sv
package fpu_stat_pkg;

   // Rounding directions as presented to the datapath
   typedef enum logic [1:0] {
      RND_NEAREST_EVEN = 2'd0,
      RND_TOWARD_ZERO  = 2'd1,
      RND_PLUS_INF     = 2'd2,
      RND_MINUS_INF    = 2'd3
   } rnd_mode_e;

   // Number of tracked exception kinds
   localparam int unsigned EXC_KINDS = 5;

   // Lowest rounding code without a supported direction
   localparam int unsigned FIRST_BAD_CODE = 4;

endpackage

// File: rtl/fsc_exc_accum.sv
module fsc_exc_accum #(
   parameter int unsigned N = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [N-1:0] load_i,
   input  logic         ev_valid_i,
   input  logic [N-1:0] ev_i,
   output logic [N-1:0] flags_o
);

   logic [N-1:0] flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
      end else if (we_i) begin
         flags_q <= load_i;
      end else if (ev_valid_i) begin
         flags_q <= flags_q | ev_i;
      end
   end

   assign flags_o = flags_q;

   // R5: a write reloads the accumulator
   p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> flags_o == $past(load_i));

   // R4: no flag is lost without a write
   p_no_loss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> (flags_o & $past(flags_o)) == $past(flags_o));

   // R4: valid events are captured
   p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i && ev_valid_i) |=> (flags_o & $past(ev_i)) == $past(ev_i));

endmodule

// File: rtl/fsc_round_ctl.sv
module fsc_round_ctl
   import fpu_stat_pkg::*;
#(
   parameter int unsigned RM_W     = 3,
   parameter bit          ERR_HOLD = 1'b0
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            we_i,
   input  logic [RM_W-1:0] new_code_i,
   input  logic [RM_W-1:0] old_code_i,
   output rnd_mode_e       mode_o,
   output logic            err_o
);

   localparam logic [RM_W-1:0] BAD_LO = RM_W'(FIRST_BAD_CODE);

   logic      changed;
   logic      bad_code;
   rnd_mode_e mode_q;
   logic      err_q;

   assign changed  = we_i && (new_code_i != old_code_i);
   assign bad_code = new_code_i >= BAD_LO;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= RND_NEAREST_EVEN;
      end else if (changed && !bad_code) begin
         mode_q <= rnd_mode_e'(new_code_i[1:0]);
      end
   end

   generate
      if (ERR_HOLD) begin : g_err_hold
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               err_q <= 1'b0;
            end else if (changed && bad_code) begin
               err_q <= 1'b1;
            end else if (we_i && !bad_code) begin
               err_q <= 1'b0;
            end
         end

         // R10: held error only falls on a supported-code write
         p_err_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (err_o && !(we_i && new_code_i < BAD_LO)) |=> err_o);
      end else begin : g_err_pulse
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               err_q <= 1'b0;
            end else begin
               err_q <= changed && bad_code;
            end
         end

         // R10: pulse needs a write one cycle earlier
         p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !we_i |=> !err_o);
      end
   endgenerate

   assign mode_o = mode_q;
   assign err_o  = err_q;

   // R8: unchanged field leaves the mode alone
   p_same_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i || new_code_i == old_code_i) |=> $stable(mode_o));

   // R9: unsupported code keeps the mode
   p_bad_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && new_code_i >= BAD_LO) |=> $stable(mode_o));

   // R9: changed unsupported code raises error
   p_bad_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && new_code_i != old_code_i && new_code_i >= BAD_LO) |=> err_o);

   // R7: supported change is adopted
   p_mode_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && new_code_i != old_code_i && new_code_i < BAD_LO)
      |=> mode_o == rnd_mode_e'($past(new_code_i[1:0])));

endmodule

// File: rtl/fpu_stat_ctl.sv
module fpu_stat_ctl
   import fpu_stat_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned RM_LSB   = 0,
   parameter int unsigned RM_W     = 3,
   parameter int unsigned FLAG_LSB = 3,
   parameter int unsigned EXC_W    = 5,
   parameter int unsigned TRAP_LSB = 8,
   parameter int unsigned CMP_BIT  = 29,
   parameter bit          ERR_HOLD = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              ev_valid_i,
   input  logic [EXC_W-1:0]  ev_flags_i,
   input  logic              cmp_valid_i,
   input  logic              cmp_result_i,
   output logic [1:0]        rnd_mode_o,
   output logic              rnd_err_o
);

   localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
   localparam logic [DATA_W-1:0] RM_FIELD   = ((ONE << RM_W) - ONE) << RM_LSB;
   localparam logic [DATA_W-1:0] FLAG_FIELD = ((ONE << EXC_W) - ONE) << FLAG_LSB;
   localparam logic [DATA_W-1:0] TRAP_FIELD = ((ONE << EXC_W) - ONE) << TRAP_LSB;
   localparam logic [DATA_W-1:0] CMP_FIELD  = ONE << CMP_BIT;
   localparam logic [DATA_W-1:0] WR_MASK    = RM_FIELD | FLAG_FIELD | TRAP_FIELD | CMP_FIELD;

   // Elaboration-time parameter checks
   generate
      if (EXC_W != EXC_KINDS) begin : g_bad_exc
         $error("EXC_W must equal the number of exception kinds");
      end
      if (RM_W < 3) begin : g_bad_rmw
         $error("RM_W must hold unsupported codes");
      end
      if (RM_LSB + RM_W > FLAG_LSB) begin : g_ovl_rm
         $error("rounding field overlaps flag field");
      end
      if (FLAG_LSB + EXC_W > TRAP_LSB) begin : g_ovl_flag
         $error("flag field overlaps trap field");
      end
      if (TRAP_LSB + EXC_W > CMP_BIT) begin : g_ovl_trap
         $error("trap field overlaps compare bit");
      end
      if (CMP_BIT >= DATA_W) begin : g_bad_cmp
         $error("compare bit outside word");
      end
   endgenerate

   logic [DATA_W-1:0] word_q;
   logic [EXC_W-1:0]  acc_flags;
   rnd_mode_e         mode_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else if (wr_en_i) begin
         word_q <= wr_data_i & WR_MASK;
      end else if (cmp_valid_i) begin
         word_q[CMP_BIT] <= cmp_result_i;
      end
   end

   fsc_exc_accum #(
      .N (EXC_W)
   ) u_accum (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (wr_en_i),
      .load_i     (wr_data_i[TRAP_LSB +: EXC_W]),
      .ev_valid_i (ev_valid_i),
      .ev_i       (ev_flags_i),
      .flags_o    (acc_flags)
   );

   fsc_round_ctl #(
      .RM_W     (RM_W),
      .ERR_HOLD (ERR_HOLD)
   ) u_round (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (wr_en_i),
      .new_code_i (wr_data_i[RM_LSB +: RM_W]),
      .old_code_i (word_q[RM_LSB +: RM_W]),
      .mode_o     (mode_w),
      .err_o      (rnd_err_o)
   );

   assign rd_data_o  = (word_q & WR_MASK) | (DATA_W'(acc_flags) << FLAG_LSB);
   assign rnd_mode_o = mode_w;

   // R2: non-flag read bits follow the masked written word
   p_wr_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (rd_data_o & ~FLAG_FIELD) == ($past(wr_data_i) & WR_MASK & ~FLAG_FIELD));

   // R11: compare result lands in its bit
   p_cmp_store_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i && cmp_valid_i) |=> rd_data_o[CMP_BIT] == $past(cmp_result_i));

   // R6: write wins over a same-cycle compare
   p_wr_prio_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> rd_data_o[CMP_BIT] == $past(wr_data_i[CMP_BIT]));

endmodule

// File: tb/fpu_stat_ctl_tb_top.sv
module fpu_stat_ctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        ev_valid = 1'b0;
   logic [4:0]  ev_flags = '0;
   logic        cmp_valid = 1'b0;
   logic        cmp_result = 1'b0;

   logic [31:0] rd_a, rd_b;
   logic [1:0]  mode_a, mode_b;
   logic        err_a, err_b;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fpu_stat_ctl dut_i (
      .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
      .rd_data_o (rd_a), .ev_valid_i (ev_valid), .ev_flags_i (ev_flags),
      .cmp_valid_i (cmp_valid), .cmp_result_i (cmp_result),
      .rnd_mode_o (mode_a), .rnd_err_o (err_a)
   );

   fpu_stat_ctl #(.ERR_HOLD(1'b1)) dut_hold_i (
      .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
      .rd_data_o (rd_b), .ev_valid_i (ev_valid), .ev_flags_i (ev_flags),
      .cmp_valid_i (cmp_valid), .cmp_result_i (cmp_result),
      .rnd_mode_o (mode_b), .rnd_err_o (err_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic do_ev(input logic v, input logic [4:0] f);
      @(negedge clk);
      ev_valid = v; ev_flags = f;
      @(negedge clk);
      ev_valid = 1'b0; ev_flags = '0;
   endtask

   task automatic do_cmp(input logic r);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_result = r;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_result = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 read", rd_a, 32'h0);
      chk("R1 mode", {30'd0, mode_a}, 32'd0);
      chk("R1 err", {31'd0, err_a}, 32'd0);
      chk("R1 err hold", {31'd0, err_b}, 32'd0);
   endtask

   task automatic t_mask();
      // rounding code 0 unchanged; trap field all ones reloads flags
      do_wr(32'hFFFF_FFF8);
      chk("R2 masked write", rd_a, 32'h2000_1FF8);
      chk("R8 no err on same code", {31'd0, err_a}, 32'd0);
      do_wr(32'h0);
      chk("R5 reload zero", rd_a, 32'h0);
   endtask

   task automatic t_events();
      do_ev(1'b1, 5'b00001);
      chk("R3 invalid at bit 3", rd_a, 32'h0000_0008);
      do_ev(1'b1, 5'b10000);
      chk("R4 sticky OR inexact", rd_a, 32'h0000_0088);
      do_ev(1'b0, 5'b01110);
      chk("R4 ignored without valid", rd_a, 32'h0000_0088);
      do_ev(1'b1, 5'b00010);
      chk("R3 divzero at bit 4", rd_a, 32'h0000_0098);
   endtask

   task automatic t_reload();
      do_wr(32'h0000_0600);
      chk("R5 trap field reloads flags", rd_a, 32'h0000_0630);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h0;
      ev_valid = 1'b1; ev_flags = 5'b11111;
      @(negedge clk);
      wr_en = 1'b0; ev_valid = 1'b0; ev_flags = '0;
      chk("R6 write beats event", rd_a, 32'h0);
   endtask

   task automatic t_round();
      do_wr(32'h1);
      chk("R7 toward zero", {30'd0, mode_a}, 32'd1);
      do_wr(32'h2);
      chk("R7 plus inf", {30'd0, mode_a}, 32'd2);
      do_wr(32'h3);
      chk("R7 minus inf", {30'd0, mode_b}, 32'd3);
      do_wr(32'h0);
      chk("R7 nearest even", {30'd0, mode_a}, 32'd0);
      chk("R7 no err", {31'd0, err_a | err_b}, 32'd0);
   endtask

   task automatic t_bad();
      do_wr(32'h4);
      chk("R9 mode kept", {30'd0, mode_a}, 32'd0);
      chk("R9 err raised", {31'd0, err_a}, 32'd1);
      chk("R9 err raised hold", {31'd0, err_b}, 32'd1);
      @(negedge clk);
      chk("R10 pulse ends", {31'd0, err_a}, 32'd0);
      chk("R10 hold stays", {31'd0, err_b}, 32'd1);
      do_wr(32'h4);
      chk("R8 same bad code no err", {31'd0, err_a}, 32'd0);
      chk("R8 same bad code hold", {31'd0, err_b}, 32'd1);
      do_wr(32'h5);
      chk("R9 code 5 err", {31'd0, err_a}, 32'd1);
      chk("R9 code 5 mode kept", {30'd0, mode_b}, 32'd0);
      do_wr(32'h2);
      chk("R10 hold cleared", {31'd0, err_b}, 32'd0);
      chk("R7 recover mode", {30'd0, mode_a}, 32'd2);
      do_wr(32'h7);
      chk("R9 code 7 mode kept", {30'd0, mode_a}, 32'd2);
      chk("R9 code 7 err", {31'd0, err_a}, 32'd1);
      do_wr(32'h2);
      chk("R10 hold cleared again", {31'd0, err_b}, 32'd0);
      chk("R2 read after bad codes", rd_a, 32'h2);
   endtask

   task automatic t_cmp();
      do_cmp(1'b1);
      chk("R11 compare set", rd_a, 32'h2000_0002);
      do_cmp(1'b0);
      chk("R11 compare clear", rd_a, 32'h0000_0002);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h2;
      cmp_valid = 1'b1; cmp_result = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; cmp_valid = 1'b0; cmp_result = 1'b0;
      chk("R6 write beats compare", rd_a, 32'h0000_0002);
   endtask

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_events();
      t_reload();
      t_round();
      t_bad();
      t_cmp();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule